// File: doc/BRIEF.md
# Sync Pulse Width Classifier

The block watches a digitised sync level, for instance the output of a slicer that is low while the video signal sits near 0 V. Each low interval counts as one sync pulse. A free-running tick counter times the pulse: its value is captured when the level falls and again when it rises. When the pulse ends, the block reports three things with a one-cycle strobe: the pulse length in ticks, the ticks since the previous accepted pulse began, and a type code.

All timing comes from modular differences of one wrapping counter, so no absolute time has to be held. With an 80 MHz clock, one tick is 12.5 ns and one microsecond is 80 ticks. The type thresholds are set for PAL, where equalising pulses are about 2 µs, line sync about 4.7 µs and field long sync about 27 µs. The input first passes through a two-flop synchroniser. Pulses too short to be sync are discarded as glitches.

Top module: `sync_width_classifier`

## Requirements
- R1: `sync_n` passes through two synchronising flops before edge detection. A report is presented in the third clock after the input returns high.
- R2: A `CNT_W`-bit tick counter advances by one every clock and wraps to zero. `rpt_width` equals the number of clocks the input was low, computed modulo 2^`CNT_W`.
- R3: `rpt_since` is the number of clocks between the start of the previous accepted pulse and the start of this one, computed modulo 2^`CNT_W`. It is zero for the first accepted pulse after reset.
- R4: A width below `EQ_LIMIT` (264) gives type code 2'b01 (equalising).
- R5: A width from `EQ_LIMIT` up to `LONG_MIN`-1 (264 to 1199) gives type code 2'b10 (horizontal sync).
- R6: A width of `LONG_MIN` (1200) or more gives type code 2'b11 (long sync).
- R7: A pulse narrower than `GLITCH_MIN` (40) gives no report. Its start is not used as the previous-pulse reference for `rpt_since`.
- R8: `rpt_valid` is high for exactly one clock per report. `rpt_kind` is 2'b00 whenever `rpt_valid` is low.
- R9: During reset and after it, `rpt_valid` is 0 and `rpt_kind` is 2'b00 until the first report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (80 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Asynchronous sync level, low during a pulse |
| rpt_valid | output | 1 | One-clock report strobe |
| rpt_kind | output | 2 | 00 none, 01 equalising, 10 horizontal, 11 long |
| rpt_width | output | CNT_W | Pulse width in ticks |
| rpt_since | output | CNT_W | Ticks since the previous accepted pulse began |

## Verification
The input is driven on falling clock edges. The falling transition is captured two clocks later, and the report appears after the third rising edge that follows the rising transition. The bench therefore samples at the falling edge three clocks after it raises the input. At that sample it expects the strobe, the width equal to the number of low clocks, and the code. At every other falling edge in the gap it expects the strobe to be low and the code to be 00. The bench runs with a 16-bit counter so that the run crosses a wrap. The reference interval is taken from the bench's own record of when each accepted pulse was driven low.

// File: rtl/sync_width_classifier.sv
module sync_width_classifier #(
  parameter int CNT_W      = 32,
  parameter int GLITCH_MIN = 40,
  parameter int EQ_LIMIT   = 264,
  parameter int LONG_MIN   = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  output logic             rpt_valid,
  output logic [1:0]       rpt_kind,
  output logic [CNT_W-1:0] rpt_width,
  output logic [CNT_W-1:0] rpt_since
);
  localparam logic [CNT_W-1:0] G_MIN = CNT_W'(GLITCH_MIN);
  localparam logic [CNT_W-1:0] E_LIM = CNT_W'(EQ_LIMIT);
  localparam logic [CNT_W-1:0] L_MIN = CNT_W'(LONG_MIN);
  localparam logic [1:0] K_NONE = 2'b00, K_EQ = 2'b01, K_HS = 2'b10, K_LONG = 2'b11;

  logic             s1, s2, s3;
  logic             in_pulse, have_ref;
  logic [CNT_W-1:0] tick, start_q, ref_q;

  wire              fall    = s3 & ~s2;
  wire              rise    = ~s3 & s2 & in_pulse;
  wire [CNT_W-1:0]  width_w = tick - start_q;
  wire              accept  = rise & (width_w >= G_MIN);
  wire [1:0]        kind_w  = (width_w < E_LIM) ? K_EQ :
                              (width_w < L_MIN) ? K_HS : K_LONG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
      tick <= '0;
    end else begin
      s1 <= sync_n;
      s2 <= s1;
      s3 <= s2;
      tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pulse  <= 1'b0;
      have_ref  <= 1'b0;
      start_q   <= '0;
      ref_q     <= '0;
      rpt_valid <= 1'b0;
      rpt_kind  <= K_NONE;
      rpt_width <= '0;
      rpt_since <= '0;
    end else begin
      rpt_valid <= accept;
      rpt_kind  <= accept ? kind_w : K_NONE;
      if (fall) begin
        start_q  <= tick;
        in_pulse <= 1'b1;
      end else if (rise) begin
        in_pulse <= 1'b0;
      end
      if (accept) begin
        rpt_width <= width_w;
        rpt_since <= have_ref ? start_q - ref_q : '0;
        ref_q     <= start_q;
        have_ref  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_width_classifier_chk.sv
module sync_width_classifier_chk #(
  parameter int CNT_W      = 32,
  parameter int GLITCH_MIN = 40,
  parameter int EQ_LIMIT   = 264,
  parameter int LONG_MIN   = 1200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rpt_valid,
  input logic [1:0]       rpt_kind,
  input logic [CNT_W-1:0] rpt_width,
  input logic [CNT_W-1:0] tick
);
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !rpt_valid);
  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid |-> rpt_kind == 2'b00);
  a_r7_no_glitch_report: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_width >= CNT_W'(GLITCH_MIN));
  a_r4_eq_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_width < CNT_W'(EQ_LIMIT)) |-> rpt_kind == 2'b01);
  a_r6_long_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_width >= CNT_W'(LONG_MIN)) |-> rpt_kind == 2'b11);
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tick == $past(tick) + 1'b1);
endmodule

bind sync_width_classifier sync_width_classifier_chk #(
  .CNT_W(CNT_W), .GLITCH_MIN(GLITCH_MIN), .EQ_LIMIT(EQ_LIMIT), .LONG_MIN(LONG_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_kind(rpt_kind),
  .rpt_width(rpt_width), .tick(tick)
);

// File: tb/sync_width_classifier_tb_top.sv
module sync_width_classifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1;
  logic rpt_valid;
  logic [1:0] rpt_kind;
  logic [W-1:0] rpt_width, rpt_since;
  int checks = 0, failures = 0;
  int cyc = 0;
  int ref_start = 0;
  bit have_ref = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_width_classifier #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .rpt_valid(rpt_valid),
    .rpt_kind(rpt_kind), .rpt_width(rpt_width), .rpt_since(rpt_since));

  function automatic logic [1:0] exp_kind(int w);
    if (w < 40) return 2'b00;
    if (w < 264) return 2'b01;
    if (w < 1200) return 2'b10;
    return 2'b11;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int n, int gap);
    int fall_at;
    logic [1:0] k;
    bit stray;
    k = exp_kind(n);
    @(negedge clk);
    sync_n = 1'b0;
    fall_at = cyc;
    repeat (n) @(negedge clk);
    sync_n = 1'b1;
    stray = 0;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i == 3) begin
        if (k == 2'b00) begin
          chk(rpt_valid == 1'b0, "R7 glitch report", rpt_valid, 0);
        end else begin
          chk(rpt_valid == 1'b1, "R1 valid timing", rpt_valid, 1);
          chk(rpt_width == W'(n), "R2 width", rpt_width, n);
          if (k == 2'b01) chk(rpt_kind == k, "R4 eq code", rpt_kind, k);
          else if (k == 2'b10) chk(rpt_kind == k, "R5 hs code", rpt_kind, k);
          else chk(rpt_kind == k, "R6 long code", rpt_kind, k);
          chk(rpt_since == (have_ref ? W'(fall_at - ref_start) : W'(0)),
              "R3 since", rpt_since, have_ref ? (fall_at - ref_start) % (1 << W) : 0);
          ref_start = fall_at;
          have_ref = 1;
        end
      end else if (rpt_valid || rpt_kind != 2'b00) begin
        stray = 1;
      end
    end
    chk(!stray, "R8 strobe width", stray, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, g, cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rpt_valid == 0, "R9 reset valid", rpt_valid, 0);
    chk(rpt_kind == 0, "R9 reset kind", rpt_kind, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rpt_valid == 0 && rpt_kind == 0, "R9 after reset", rpt_valid, 0);
    pulse(39, 20);
    pulse(40, 30);
    pulse(263, 6);
    pulse(264, 50);
    pulse(1199, 8);
    pulse(1200, 100);
    pulse(12, 10);
    pulse(376, 5);
    pulse(2160, 200);
    pulse(160, 2500);
    cnt = 0;
    while ((cnt < 60 || cyc < 70000) && cnt < 120) begin
      n = 1 + int'($urandom % 2500);
      g = 5 + int'($urandom % 300);
      pulse(n, g);
      cnt++;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule